// File: doc/BRIEF.md
# Filtered PCIe Traffic Event Counter

This block watches a tap on PCIe transaction-layer traffic and counts the packets that pass a programmable set of filters. On each cycle the tap may present one packet observation: a valid flag, the index of the root-port slot it came through, the 16-bit requester ID (bus/device/function), the payload length in doublewords and the byte count. Depending on the selected event class, the 64-bit counter adds either one per qualifying packet or that packet's byte count. The counter saturates at its maximum value and does not wrap.

Four filters decide which packets qualify. The first is a bitmap of root-port slots. The second is an exact requester-ID match. The third is a one-shot length trigger that opens counting at the first packet longer (or shorter) than a power-of-two length. The fourth is a per-packet length window against a second power-of-two threshold. Software drives the configuration inputs, pulses a clear, and reads the registered counter value. Configurations that cannot be honoured are flagged on `cfg_reject`, and the counter does not count while they are applied.

Top module: `pcnt_counter`

## Requirements
- R1: After reset the counter reads 0. A clear pulse sets it to 0 on the next clock edge, and the clear takes priority over an increment in the same cycle.
- R2: The event class code selects what is counted: 0 is bandwidth, 1 is an application-layer packet count, 2 is a link-layer packet count and 3 is reserved. Bandwidth adds the packet byte count, and both count classes add 1 per qualifying packet. While the counter is disabled, or no packet is valid, the value holds. The counter value is registered, so a packet accepted at an edge is visible after that edge.
- R3: The counter saturates at all ones and never wraps or decreases except by clear.
- R4: A nonzero port bitmap passes only packets whose slot index has its bit set, where bit i matches slot i. Several bits may be set for bandwidth and application-layer events. A bitmap of 0 disables port filtering.
- R5: With requester-ID filtering enabled and a bandwidth event selected, only packets whose 16-bit requester ID equals the programmed value count. For other event classes the requester-ID filter is ignored.
- R6: A nonzero port bitmap together with requester-ID filtering enabled raises `cfg_reject`, and nothing counts.
- R7: A link-layer event (class 2) with more than one port bit set, or the reserved class 3, raises `cfg_reject`, and nothing counts.
- R8: Trigger mode 0 with length selector n opens counting at the first packet that passes the port and requester filters and is longer than 2^n doublewords. That packet is itself counted if it passes the threshold filter.
- R9: Trigger mode 1 opens counting at the first such packet shorter than 2^n doublewords. Once open, counting stays open for every later packet whatever its length. The trigger is re-armed by a clear, or while the counter is disabled or rejected.
- R10: Threshold mode 0 with selector n counts only packets of at least 2^n doublewords. Threshold mode 1 counts only packets shorter than 2^n.
- R11: A length field of 0 means 1024 doublewords in the trigger and threshold comparisons.
- R12: For the two count classes the trigger and threshold filters are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Counter enable |
| cfg_clear | input | 1 | Clear pulse, zeroes counter and trigger latch |
| cfg_event | input | 2 | Event class: 0 bandwidth, 1 application count, 2 link count, 3 reserved |
| cfg_port_mask | input | 16 | Root-port slot bitmap, 0 = any slot |
| cfg_rid_en | input | 1 | Enable requester-ID match |
| cfg_rid | input | 16 | Requester ID to match |
| cfg_trig_en | input | 1 | Enable length trigger |
| cfg_trig_len | input | 4 | Trigger length selector n (2^n doublewords) |
| cfg_trig_mode | input | 1 | 0: longer than, 1: shorter than |
| cfg_thr_en | input | 1 | Enable length threshold |
| cfg_thr_len | input | 4 | Threshold selector n (2^n doublewords) |
| cfg_thr_mode | input | 1 | 0: at least, 1: below |
| pkt_valid | input | 1 | Packet observation valid this cycle |
| pkt_port | input | 4 | Root-port slot index |
| pkt_rid | input | 16 | Requester ID |
| pkt_len_dw | input | 10 | Length in doublewords, 0 = 1024 |
| pkt_bytes | input | 13 | Byte count of the packet |
| cnt_value | output | 64 | Counter value as of the last clock edge |
| cfg_reject | output | 1 | Current configuration is rejected |

## Verification
The assertions assume that the configuration inputs change only between packet observations that software regards as separate runs. They also assume that the clear is a single-cycle pulse and that `pkt_port` is always a legal slot index below 16. The stimulus changes configuration only at negative edges, draws port indices from 0 to 15, and issues clears as isolated one-cycle pulses. The random phase biases requester IDs to match the programmed value half of the time, and biases port bitmaps toward zero, single-bit and multi-bit masks, so that each filter path and each rejection case is reached repeatedly.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    localparam int NPORT  = 16;
    localparam int PORT_W = $clog2(NPORT);
    localparam int RID_W  = 16;
    localparam int LEN_W  = 10;
    localparam int LSEL_W = 4;
    localparam int POW_W  = (1 << LSEL_W);
    localparam int CMP_W  = (POW_W > LEN_W + 1) ? POW_W : LEN_W + 1;

    typedef enum logic [1:0] {
        EV_BW   = 2'd0,
        EV_APP  = 2'd1,
        EV_LINK = 2'd2,
        EV_RSVD = 2'd3
    } ev_class_e;

    typedef struct packed {
        ev_class_e          ev;
        logic [NPORT-1:0]   port_mask;
        logic               rid_en;
        logic [RID_W-1:0]   rid;
        logic               trig_en;
        logic [LSEL_W-1:0]  trig_len;
        logic               trig_mode;
        logic               thr_en;
        logic [LSEL_W-1:0]  thr_len;
        logic               thr_mode;
    } pcnt_cfg_t;

    typedef struct packed {
        logic               valid;
        logic [PORT_W-1:0]  port;
        logic [RID_W-1:0]   rid;
        logic [LEN_W-1:0]   len;
    } pcnt_hdr_t;

    function automatic logic [CMP_W-1:0] eff_len(input logic [LEN_W-1:0] l);
        logic [CMP_W-1:0] r;
        if (l == '0) r = CMP_W'(1) << LEN_W;
        else         r = CMP_W'(l);
        return r;
    endfunction

    function automatic logic [CMP_W-1:0] pow2(input logic [LSEL_W-1:0] n);
        return CMP_W'(1) << n;
    endfunction

endpackage

// File: rtl/pcnt_cfg_check.sv
module pcnt_cfg_check
    import pcnt_pkg::*;
(
    input  pcnt_cfg_t cfg,
    output logic      reject,
    output logic      bw_class
);
    logic multi_port;
    logic dual_filter;
    logic bad_class;

    always_comb begin
        multi_port  = ($countones(cfg.port_mask) > 1);
        dual_filter = (cfg.port_mask != '0) && cfg.rid_en;
        bad_class   = (cfg.ev == EV_RSVD) || ((cfg.ev == EV_LINK) && multi_port);
        reject      = dual_filter || bad_class;
        bw_class    = (cfg.ev == EV_BW);
    end
endmodule

// File: rtl/pcnt_pkt_filter.sv
module pcnt_pkt_filter
    import pcnt_pkg::*;
(
    input  pcnt_cfg_t cfg,
    input  pcnt_hdr_t hdr,
    input  logic      bw_class,
    output logic      tgt_ok,
    output logic      trig_hit,
    output logic      thr_ok
);
    logic [NPORT-1:0] slot_sel;
    logic             port_ok;
    logic             rid_ok;
    logic [CMP_W-1:0] len_v;
    logic [CMP_W-1:0] trig_lim;
    logic [CMP_W-1:0] thr_lim;

    for (genvar g = 0; g < NPORT; g++) begin : g_slot
        assign slot_sel[g] = cfg.port_mask[g] && (hdr.port == PORT_W'(g));
    end

    always_comb begin
        port_ok  = (cfg.port_mask == '0) || (|slot_sel);
        rid_ok   = !(cfg.rid_en && bw_class) || (hdr.rid == cfg.rid);
        tgt_ok   = port_ok && rid_ok;
        len_v    = eff_len(hdr.len);
        trig_lim = pow2(cfg.trig_len);
        thr_lim  = pow2(cfg.thr_len);
        trig_hit = cfg.trig_mode ? (len_v < trig_lim) : (len_v > trig_lim);
        if (!(cfg.thr_en && bw_class)) thr_ok = 1'b1;
        else if (cfg.thr_mode)         thr_ok = (len_v < thr_lim);
        else                           thr_ok = (len_v >= thr_lim);
    end
endmodule

// File: rtl/pcnt_trig_latch.sv
module pcnt_trig_latch (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic need,
    input  logic hit_now,
    output logic gate_open
);
    logic fired_q;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) fired_q <= 1'b0;
        else if (need && hit_now) fired_q <= 1'b1;
    end

    assign gate_open = !need || fired_q || hit_now;
endmodule

// File: rtl/pcnt_accum.sv
module pcnt_accum #(
    parameter int CNT_W  = 64,
    parameter int BYTE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    input  logic [BYTE_W-1:0] amt,
    output logic [CNT_W-1:0]  value
);
    logic [CNT_W:0] sum;

    assign sum = {1'b0, value} + (CNT_W + 1)'(amt);

    always_ff @(posedge clk) begin
        if (rst || clear)  value <= '0;
        else if (inc)      value <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
endmodule

// File: rtl/pcnt_counter.sv
module pcnt_counter
    import pcnt_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int BYTE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_clear,
    input  logic [1:0]        cfg_event,
    input  logic [15:0]       cfg_port_mask,
    input  logic              cfg_rid_en,
    input  logic [15:0]       cfg_rid,
    input  logic              cfg_trig_en,
    input  logic [3:0]        cfg_trig_len,
    input  logic              cfg_trig_mode,
    input  logic              cfg_thr_en,
    input  logic [3:0]        cfg_thr_len,
    input  logic              cfg_thr_mode,
    input  logic              pkt_valid,
    input  logic [3:0]        pkt_port,
    input  logic [15:0]       pkt_rid,
    input  logic [9:0]        pkt_len_dw,
    input  logic [BYTE_W-1:0] pkt_bytes,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              cfg_reject
);
    pcnt_cfg_t        cfg;
    pcnt_hdr_t        hdr;
    logic             bw_class;
    logic             tgt_ok;
    logic             trig_hit;
    logic             thr_ok;
    logic             run;
    logic             gate_open;
    logic             inc;
    logic [BYTE_W-1:0] amt;

    always_comb begin
        cfg.ev        = ev_class_e'(cfg_event);
        cfg.port_mask = cfg_port_mask;
        cfg.rid_en    = cfg_rid_en;
        cfg.rid       = cfg_rid;
        cfg.trig_en   = cfg_trig_en;
        cfg.trig_len  = cfg_trig_len;
        cfg.trig_mode = cfg_trig_mode;
        cfg.thr_en    = cfg_thr_en;
        cfg.thr_len   = cfg_thr_len;
        cfg.thr_mode  = cfg_thr_mode;
        hdr.valid     = pkt_valid;
        hdr.port      = pkt_port;
        hdr.rid       = pkt_rid;
        hdr.len       = pkt_len_dw;
    end

    pcnt_cfg_check u_check (
        .cfg      (cfg),
        .reject   (cfg_reject),
        .bw_class (bw_class)
    );

    pcnt_pkt_filter u_filter (
        .cfg      (cfg),
        .hdr      (hdr),
        .bw_class (bw_class),
        .tgt_ok   (tgt_ok),
        .trig_hit (trig_hit),
        .thr_ok   (thr_ok)
    );

    assign run = cfg_enable && !cfg_reject;

    pcnt_trig_latch u_trig (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_clear),
        .run       (run),
        .need      (cfg_trig_en && bw_class),
        .hit_now   (hdr.valid && tgt_ok && trig_hit),
        .gate_open (gate_open)
    );

    assign inc = hdr.valid && run && tgt_ok && gate_open && thr_ok;
    assign amt = bw_class ? pkt_bytes : BYTE_W'(1);

    pcnt_accum #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .clear (cfg_clear),
        .inc   (inc),
        .amt   (amt),
        .value (cnt_value)
    );
endmodule

// File: rtl/pcnt_counter_chk.sv
module pcnt_counter_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_clear,
    input logic [1:0]       cfg_event,
    input logic [15:0]      cfg_port_mask,
    input logic             cfg_rid_en,
    input logic             pkt_valid,
    input logic             cfg_reject,
    input logic [CNT_W-1:0] cnt_value
);
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> (cnt_value == '0));                                   // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_clear && (!cfg_enable || !pkt_valid)) |=> $stable(cnt_value)); // R2

    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        !cfg_clear |=> (cnt_value >= $past(cnt_value)));                   // R3

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_clear && (cnt_value == '1)) |=> (cnt_value == '1));           // R3

    AST_DUAL_REJECT: assert property (@(posedge clk) disable iff (rst)
        ((cfg_port_mask != '0) && cfg_rid_en) |-> cfg_reject);              // R6

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_clear && cfg_reject) |=> $stable(cnt_value));                 // R6

    AST_LINK_MULTI: assert property (@(posedge clk) disable iff (rst)
        ((cfg_event == 2'd2) && ($countones(cfg_port_mask) > 1)) |-> cfg_reject); // R7
endmodule

bind pcnt_counter pcnt_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_enable    (cfg_enable),
    .cfg_clear     (cfg_clear),
    .cfg_event     (cfg_event),
    .cfg_port_mask (cfg_port_mask),
    .cfg_rid_en    (cfg_rid_en),
    .pkt_valid     (pkt_valid),
    .cfg_reject    (cfg_reject),
    .cnt_value     (cnt_value)
);

// File: tb/pcnt_counter_tb_top.sv
module pcnt_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_clear = 1'b0;
    logic [1:0]  cfg_event = 2'd0;
    logic [15:0] cfg_port_mask = '0;
    logic        cfg_rid_en = 1'b0;
    logic [15:0] cfg_rid = '0;
    logic        cfg_trig_en = 1'b0;
    logic [3:0]  cfg_trig_len = '0;
    logic        cfg_trig_mode = 1'b0;
    logic        cfg_thr_en = 1'b0;
    logic [3:0]  cfg_thr_len = '0;
    logic        cfg_thr_mode = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [3:0]  pkt_port = '0;
    logic [15:0] pkt_rid = '0;
    logic [9:0]  pkt_len_dw = 10'd1;
    logic [12:0] pkt_bytes = '0;
    logic [63:0] cnt_value;
    logic        cfg_reject;
    logic [15:0] cnt_small;
    logic        rej_small;

    always #4 clk = ~clk;

    pcnt_counter dut_i (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
        .cfg_event(cfg_event), .cfg_port_mask(cfg_port_mask), .cfg_rid_en(cfg_rid_en),
        .cfg_rid(cfg_rid), .cfg_trig_en(cfg_trig_en), .cfg_trig_len(cfg_trig_len),
        .cfg_trig_mode(cfg_trig_mode), .cfg_thr_en(cfg_thr_en), .cfg_thr_len(cfg_thr_len),
        .cfg_thr_mode(cfg_thr_mode), .pkt_valid(pkt_valid), .pkt_port(pkt_port),
        .pkt_rid(pkt_rid), .pkt_len_dw(pkt_len_dw), .pkt_bytes(pkt_bytes),
        .cnt_value(cnt_value), .cfg_reject(cfg_reject)
    );

    pcnt_counter #(.CNT_W(16)) sat_i (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
        .cfg_event(cfg_event), .cfg_port_mask(cfg_port_mask), .cfg_rid_en(cfg_rid_en),
        .cfg_rid(cfg_rid), .cfg_trig_en(cfg_trig_en), .cfg_trig_len(cfg_trig_len),
        .cfg_trig_mode(cfg_trig_mode), .cfg_thr_en(cfg_thr_en), .cfg_thr_len(cfg_thr_len),
        .cfg_thr_mode(cfg_thr_mode), .pkt_valid(pkt_valid), .pkt_port(pkt_port),
        .pkt_rid(pkt_rid), .pkt_len_dw(pkt_len_dw), .pkt_bytes(pkt_bytes),
        .cnt_value(cnt_small), .cfg_reject(rej_small)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 0;

    longint unsigned m_big = 0;
    longint unsigned m_small = 0;
    bit              m_latch = 0;

    function automatic bit exp_reject();
        int ones = $countones(cfg_port_mask);
        return (cfg_port_mask != 0 && cfg_rid_en) || cfg_event == 2'd3 ||
               (cfg_event == 2'd2 && ones > 1);
    endfunction

    function automatic longint unsigned sat_add(longint unsigned v, longint unsigned a,
                                                longint unsigned lim);
        return (v > lim - a) ? lim : v + a;
    endfunction

    task automatic model_step();
        bit bw, run, tgt, need, hit, open, thr, inc;
        int unsigned len, tlim, hlim;
        longint unsigned amt;
        bw   = (cfg_event == 2'd0);
        run  = cfg_enable && !exp_reject();
        len  = (pkt_len_dw == 0) ? 1024 : int'(pkt_len_dw);
        tlim = 1 << cfg_trig_len;
        hlim = 1 << cfg_thr_len;
        tgt  = (cfg_port_mask == 0 || cfg_port_mask[pkt_port]) &&
               (!(cfg_rid_en && bw) || pkt_rid == cfg_rid);
        need = cfg_trig_en && bw;
        hit  = pkt_valid && tgt && (cfg_trig_mode ? (len < tlim) : (len > tlim));
        open = !need || m_latch || hit;
        thr  = !(cfg_thr_en && bw) || (cfg_thr_mode ? (len < hlim) : (len >= hlim));
        inc  = pkt_valid && run && tgt && open && thr;
        amt  = bw ? longint'(pkt_bytes) : 1;
        if (rst || cfg_clear) begin
            m_big = 0; m_small = 0;
        end else if (inc) begin
            m_big   = sat_add(m_big, amt, 64'hFFFF_FFFF_FFFF_FFFF);
            m_small = sat_add(m_small, amt, 64'hFFFF);
        end
        if (rst || cfg_clear || !run) m_latch = 0;
        else if (need && hit)         m_latch = 1;
    endtask

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, cnt_value, m_big);
        check(req, longint'(cnt_small), m_small);
        check(req, longint'(cfg_reject), longint'(exp_reject()));
    endtask

    task automatic pkt(string req, bit v, int port, int rid, int len, int bytes);
        pkt_valid  = v;
        pkt_port   = 4'(port);
        pkt_rid    = 16'(rid);
        pkt_len_dw = 10'(len);
        pkt_bytes  = 13'(bytes);
        tick(req);
        pkt_valid  = 1'b0;
    endtask

    task automatic clr(string req);
        cfg_clear = 1'b1;
        tick(req);
        cfg_clear = 1'b0;
    endtask

    task automatic cfg_default(int ev);
        cfg_event = 2'(ev); cfg_port_mask = '0; cfg_rid_en = 0; cfg_rid = '0;
        cfg_trig_en = 0; cfg_trig_len = '0; cfg_trig_mode = 0;
        cfg_thr_en = 0; cfg_thr_len = '0; cfg_thr_mode = 0; cfg_enable = 1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        model_step();
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset", cnt_value, 0);
        check("R1 reset", longint'(cnt_small), 0);

        // R2 application-layer count, then disabled hold
        cfg_default(1);
        for (int i = 0; i < 5; i++) pkt("R2", 1, i, 0, 4, 100);
        check("R2 app count", cnt_value, 5);
        cfg_enable = 0;
        pkt("R2 disabled", 1, 0, 0, 4, 100);
        check("R2 disabled hold", cnt_value, 5);
        cfg_enable = 1;
        clr("R1");
        // R1 clear beats a simultaneous packet
        cfg_default(0);
        pkt("R2", 1, 0, 0, 8, 300);
        cfg_clear = 1;
        pkt("R1 clear priority", 1, 0, 0, 8, 300);
        cfg_clear = 0;
        check("R1 clear priority", cnt_value, 0);
        // R2 bandwidth bytes
        pkt("R2", 1, 2, 0, 8, 64);
        pkt("R2", 1, 3, 0, 8, 200);
        check("R2 bytes", cnt_value, 264);
        clr("R1");

        // R4 multi-bit port mask
        cfg_default(0); cfg_port_mask = 16'h0088;
        pkt("R4", 1, 3, 0, 4, 10);
        pkt("R4", 1, 7, 0, 4, 20);
        pkt("R4", 1, 5, 0, 4, 40);
        check("R4 port mask", cnt_value, 30);
        clr("R1");

        // R5 requester-ID match for bandwidth, ignored for counts
        cfg_default(0); cfg_rid_en = 1; cfg_rid = 16'h3900;
        pkt("R5", 1, 0, 16'h3900, 4, 50);
        pkt("R5", 1, 0, 16'h3901, 4, 50);
        check("R5 rid match", cnt_value, 50);
        clr("R1");
        cfg_event = 2'd1;
        pkt("R5", 1, 0, 16'h1111, 4, 50);
        check("R5 rid ignored", cnt_value, 1);
        clr("R1");

        // R6 port plus requester filter rejected
        cfg_default(0); cfg_rid_en = 1; cfg_rid = 16'h0100; cfg_port_mask = 16'h0001;
        pkt("R6", 1, 0, 16'h0100, 4, 50);
        check("R6 reject flag", longint'(cfg_reject), 1);
        check("R6 no count", cnt_value, 0);

        // R7 link-layer multi-port and reserved class
        cfg_default(2); cfg_port_mask = 16'h0101;
        pkt("R7", 1, 0, 0, 4, 50);
        check("R7 link multi reject", cnt_value, 0);
        cfg_port_mask = 16'h0100;
        pkt("R7", 1, 8, 0, 4, 50);
        check("R7 link single ok", cnt_value, 1);
        cfg_default(3);
        pkt("R7", 1, 0, 0, 4, 50);
        check("R7 reserved", cnt_value, 1);
        clr("R1");

        // R8 trigger mode 0, 2^4 = 16 dw
        cfg_default(0); cfg_trig_en = 1; cfg_trig_len = 4'd4;
        pkt("R8", 1, 0, 0, 8, 1);
        pkt("R8", 1, 0, 0, 16, 2);
        pkt("R8", 1, 0, 0, 20, 4);
        pkt("R8", 1, 0, 0, 3, 8);
        check("R8 trigger longer", cnt_value, 12);
        clr("R1");

        // R9 trigger mode 1, 2^3 = 8 dw, re-arm on clear
        cfg_trig_mode = 1; cfg_trig_len = 4'd3;
        pkt("R9", 1, 0, 0, 8, 1);
        pkt("R9", 1, 0, 0, 9, 2);
        pkt("R9", 1, 0, 0, 5, 4);
        pkt("R9", 1, 0, 0, 300, 8);
        check("R9 trigger shorter", cnt_value, 12);
        clr("R9");
        pkt("R9", 1, 0, 0, 100, 16);
        check("R9 rearmed", cnt_value, 0);
        clr("R1");

        // R10 threshold both senses, 2^5 = 32 dw
        cfg_default(0); cfg_thr_en = 1; cfg_thr_len = 4'd5;
        pkt("R10", 1, 0, 0, 31, 1);
        pkt("R10", 1, 0, 0, 32, 2);
        check("R10 at least", cnt_value, 2);
        cfg_thr_mode = 1;
        pkt("R10", 1, 0, 0, 31, 4);
        pkt("R10", 1, 0, 0, 32, 8);
        check("R10 below", cnt_value, 6);
        clr("R1");

        // R11 length 0 means 1024
        cfg_default(0); cfg_thr_en = 1; cfg_thr_len = 4'd10;
        pkt("R11", 1, 0, 0, 0, 7);
        pkt("R11", 1, 0, 0, 1023, 9);
        check("R11 zero is 1024", cnt_value, 7);
        clr("R1");

        // R12 trigger and threshold ignored for count classes
        cfg_default(1); cfg_thr_en = 1; cfg_thr_len = 4'd9; cfg_trig_en = 1; cfg_trig_len = 4'd9;
        pkt("R12", 1, 0, 0, 2, 5);
        check("R12 ignored", cnt_value, 1);
        clr("R1");

        // R3 saturation on 16-bit instance
        cfg_default(0);
        for (int i = 0; i < 20; i++) pkt("R3", 1, 0, 0, 4, 4095);
        check("R3 saturate", longint'(cnt_small), 65535);
        clr("R1");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) begin
                cfg_event     = 2'($urandom % 4);
                case ($urandom % 3)
                    0: cfg_port_mask = '0;
                    1: cfg_port_mask = 16'(1) << ($urandom % 16);
                    default: cfg_port_mask = 16'($urandom);
                endcase
                cfg_rid_en    = (($urandom % 4) == 0);
                cfg_rid       = 16'($urandom);
                cfg_trig_en   = 1'($urandom);
                cfg_trig_len  = 4'($urandom % 11);
                cfg_trig_mode = 1'($urandom);
                cfg_thr_en    = 1'($urandom);
                cfg_thr_len   = 4'($urandom % 11);
                cfg_thr_mode  = 1'($urandom);
            end
            cfg_enable = (($urandom % 20) != 0);
            cfg_clear  = (($urandom % 100) == 0);
            pkt("R2 random", (($urandom % 4) != 0), int'($urandom % 16),
                (($urandom % 2) == 0) ? int'(cfg_rid) : int'($urandom % 65536),
                int'($urandom % 1024), int'($urandom % 8192));
            cfg_clear = 0;
        end
        summary();
    end
endmodule